// File: doc/BRIEF.md
# DAC Level Command Decoder

This block sits on the serial control bus of a mixed-signal chip. It receives 24-bit commands as three bytes and keeps the 8-bit level settings of three digital-to-analog converters. It also drives the power control of those converters. A frame is framed by an active-high select line. Bits arrive most significant bit first and the first byte first, one bit on each cycle where the bit strobe is high while select is high. A frame takes effect only when select goes low after exactly 24 strobes.

A command is acted on only when it is of the normal type. Three scattered flag bits then route the first byte to any mix of the three level registers. One bit in the second byte gives the commanded power state of the third converter. A sleep input forces the third converter off. It also tells the first two converters to run with reduced drive strength, while they stay powered.

Top module: `dac_level_decoder`

## Requirements
- R1: A frame is acted on only when bits 7:6 of its second byte are 01. Any other value in those bits leaves all levels and the power state unchanged.
- R2: When bit 3 of the third byte is 1, the first byte is loaded into `lvl1`.
- R3: When bit 2 of the third byte is 1, the first byte is loaded into `lvl2`.
- R4: When bit 1 of the second byte is 1, the first byte is loaded into `lvl3`.
- R5: Any number of the three load flags may be set together. Every flagged register takes the same first byte, and unflagged registers keep their value.
- R6: Every accepted command copies bit 3 of its second byte into the commanded power state of the third converter, where 1 means on and 0 means off.
- R7: While `sleep` is 1, `dac3_pwr` is 0 and `drive_low` is 1, whatever the commanded state. When `sleep` returns to 0, `dac3_pwr` shows the commanded state again, including any command accepted during sleep.
- R8: After reset, all three levels are 0, `dac3_pwr` is 1 (with `sleep` low) and `drive_low` is 0.
- R9: A frame counts only if exactly 24 strobes arrive while `ser_en` is high. A frame with fewer or more strobes is dropped when `ser_en` falls, and strobes while `ser_en` is low are ignored.
- R10: The outputs change on the first rising clock edge that samples `ser_en` low after a complete frame, and never while `ser_en` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_en | input | 1 | Frame select, high during a command |
| ser_stb | input | 1 | Bit strobe; one bit is taken per cycle it is high |
| ser_dat | input | 1 | Serial data bit, MSB first |
| sleep | input | 1 | Sleep mode request |
| lvl1 | output | DW | Level of converter 1 |
| lvl2 | output | DW | Level of converter 2 |
| lvl3 | output | DW | Level of converter 3 |
| dac3_pwr | output | 1 | Power enable of converter 3 |
| drive_low | output | 1 | Reduced drive request for converters 1 and 2 |

## Verification
A bad bit counter or a flag latched at the wrong bit position shows up at the end of that same frame. Such a fault either loads the wrong registers or drops a frame that should be accepted, and it becomes visible one clock after `ser_en` falls. A stale commanded power state stays hidden while `sleep` is high. It only shows up on `dac3_pwr` in the cycle `sleep` is released, so the bench sends a command during sleep and then wakes the block. Strobes outside a frame and frames of 23 or 25 bits check that the counter cannot drift from one frame into the next.

// File: rtl/dac_level_decoder.sv
module dac_level_decoder #(
  parameter int DW     = 8,
  parameter int NBYTES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_en,
  input  logic          ser_stb,
  input  logic          ser_dat,
  input  logic          sleep,
  output logic [DW-1:0] lvl1,
  output logic [DW-1:0] lvl2,
  output logic [DW-1:0] lvl3,
  output logic          dac3_pwr,
  output logic          drive_low
);
  localparam int FW = DW * NBYTES;
  localparam int CW = $clog2(FW + 2);
  localparam logic [CW-1:0] FULL = CW'(FW);
  localparam logic [CW-1:0] OVER = CW'(FW + 1);
  localparam logic [CW-1:0] K_DATA = CW'(DW);
  localparam logic [CW-1:0] K_T1 = CW'(DW);
  localparam logic [CW-1:0] K_T0 = CW'(DW + 1);
  localparam logic [CW-1:0] K_PW = CW'(2*DW - 1 - 3);
  localparam logic [CW-1:0] K_F3 = CW'(2*DW - 1 - 1);
  localparam logic [CW-1:0] K_F1 = CW'(FW - 1 - 3);
  localparam logic [CW-1:0] K_F2 = CW'(FW - 1 - 2);

  logic [CW-1:0] cnt;
  logic [DW-1:0] data;
  logic [1:0]    typ;
  logic          f1, f2, f3, pw;
  logic          en_q, dac3_on;

  wire take   = ser_en & ser_stb;
  wire commit = en_q & ~ser_en & (cnt == FULL) & (typ == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      data <= '0;
      typ  <= '0;
      f1   <= 1'b0;
      f2   <= 1'b0;
      f3   <= 1'b0;
      pw   <= 1'b0;
      en_q <= 1'b0;
    end else begin
      en_q <= ser_en;
      if (take) begin
        if (cnt != OVER) cnt <= cnt + CW'(1);
        if (cnt < K_DATA) data <= {data[DW-2:0], ser_dat};
        if (cnt == K_T1) typ[1] <= ser_dat;
        if (cnt == K_T0) typ[0] <= ser_dat;
        if (cnt == K_PW) pw <= ser_dat;
        if (cnt == K_F3) f3 <= ser_dat;
        if (cnt == K_F1) f1 <= ser_dat;
        if (cnt == K_F2) f2 <= ser_dat;
      end else if (!ser_en) begin
        cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl1    <= '0;
      lvl2    <= '0;
      lvl3    <= '0;
      dac3_on <= 1'b1;
    end else if (commit) begin
      if (f1) lvl1 <= data;
      if (f2) lvl2 <= data;
      if (f3) lvl3 <= data;
      dac3_on <= pw;
    end
  end

  assign dac3_pwr  = dac3_on & ~sleep;
  assign drive_low = sleep;
endmodule

// File: rtl/dac_level_decoder_chk.sv
module dac_level_decoder_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_en,
  input logic          sleep,
  input logic [DW-1:0] lvl1,
  input logic [DW-1:0] lvl2,
  input logic [DW-1:0] lvl3,
  input logic          dac3_pwr,
  input logic          drive_low
);
  AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |=> ($stable(lvl1) && $stable(lvl2) && $stable(lvl3))); // R10

  AST_SLEEP_DAC3_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dac3_pwr); // R7

  AST_SLEEP_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> drive_low); // R7

  AST_PWR_ONLY_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac3_pwr) && $stable(sleep)) |-> ($past(ser_en, 2) && !$past(ser_en))); // R9

  AST_LVL_ONLY_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(lvl1) && $stable(lvl2) && $stable(lvl3)) |-> ($past(ser_en, 2) && !$past(ser_en))); // R9
endmodule

bind dac_level_decoder dac_level_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .sleep(sleep),
  .lvl1(lvl1), .lvl2(lvl2), .lvl3(lvl3),
  .dac3_pwr(dac3_pwr), .drive_low(drive_low)
);

// File: tb/sim_dac_level_decoder.sv
`timescale 1ns/1ps
module sim_dac_level_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_en = 1'b0, ser_stb = 1'b0, ser_dat = 1'b0, sleep = 1'b0;
  logic [7:0] lvl1, lvl2, lvl3;
  logic dac3_pwr, drive_low;

  always #2.5 clk = ~clk;

  dac_level_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_stb(ser_stb), .ser_dat(ser_dat),
    .sleep(sleep), .lvl1(lvl1), .lvl2(lvl2), .lvl3(lvl3),
    .dac3_pwr(dac3_pwr), .drive_low(drive_low)
  );

  typedef struct packed { logic [7:0] a, b, c; logic on; } exp_t;
  exp_t q[$];
  string tags[$];
  logic [7:0] m1 = 0, m2 = 0, m3 = 0;
  logic mon = 1'b1;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(string req, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3, int nbits);
    logic [24:0] fr;
    exp_t e;
    fr = {1'b1, b1, b2, b3};
    @(negedge clk) ser_en = 1'b1;
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_stb = 1'b1;
      ser_dat = (nbits == 23) ? fr[i+1] : fr[i];
    end
    @(negedge clk) ser_stb = 1'b0; ser_dat = 1'b0;
    @(negedge clk) ser_en = 1'b0;
    #1 chk("R10", lvl1, m1);
    if (nbits == 24 && b2[7:6] == 2'b01) begin
      if (b3[3]) m1 = b1;
      if (b3[2]) m2 = b1;
      if (b2[1]) m3 = b1;
      mon = b2[3];
    end
    @(posedge clk) #1;
    e = '{a: m1, b: m2, c: m3, on: mon};
    q.push_back(e);
    tags.push_back(req);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    string t;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        t = tags.pop_front();
        chk({t, " lvl1"}, lvl1, e.a);
        chk({t, " lvl2"}, lvl2, e.b);
        chk({t, " lvl3"}, lvl3, e.c);
        chk({t, " pwr"}, dac3_pwr, e.on & ~sleep);
      end
    end
  end

  initial begin : watchdog
    #500us;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 lvl1", lvl1, 0); chk("R8 lvl2", lvl2, 0); chk("R8 lvl3", lvl3, 0);
    chk("R8 pwr", dac3_pwr, 1); chk("R8 drv", drive_low, 0);

    send("R2", 8'hA5, 8'h48, 8'h08, 24);
    send("R3", 8'h3C, 8'h48, 8'h04, 24);
    send("R4", 8'h7E, 8'h4A, 8'h00, 24);
    send("R5", 8'hC3, 8'h4A, 8'h0C, 24);
    send("R5", 8'h5A, 8'h48, 8'h04, 24);
    send("R1", 8'h11, 8'h8A, 8'h0C, 24);
    send("R1", 8'h22, 8'hC2, 8'h0C, 24);
    send("R1", 8'h33, 8'h0A, 8'h0C, 24);
    send("R6", 8'h00, 8'h40, 8'h00, 24);
    send("R6", 8'h00, 8'h48, 8'h00, 24);
    send("R9", 8'h99, 8'h4A, 8'h0C, 23);
    send("R9", 8'h98, 8'h4A, 8'h0C, 25);
    repeat (5) begin
      @(negedge clk) ser_stb = 1'b1; ser_dat = 1'b1;
    end
    @(negedge clk) ser_stb = 1'b0; ser_dat = 1'b0;
    send("R9", 8'h6B, 8'h4A, 8'h0C, 24);

    @(negedge clk) sleep = 1'b1;
    #1 chk("R7 pwr", dac3_pwr, 0); chk("R7 drv", drive_low, 1);
    send("R7", 8'h0F, 8'h40, 8'h08, 24);
    send("R7", 8'hF0, 8'h48, 8'h04, 24);
    @(negedge clk) sleep = 1'b0;
    #1 chk("R7 wake", dac3_pwr, 1); chk("R7 drv", drive_low, 0);
    send("R6", 8'h44, 8'h42, 8'h00, 24);
    @(negedge clk) sleep = 1'b1;
    @(negedge clk) sleep = 1'b0;
    #1 chk("R7 stay off", dac3_pwr, 0);

    repeat (4) @(negedge clk);
    chk("R10 queue empty", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule